// File: doc/BRIEF.md
# Shared-Memory Burst Regrouping Buffer

This block sits between a producer of wide data words, each carrying a destination-channel tag, and a memory bus master that performs best when it moves long runs of words to a single destination. It has one physical storage array, divided into equal fixed regions, one region per destination channel. Each region behaves as its own circular FIFO. Incoming words may name any channel in any order. Each word is stored in the region its tag selects. In any cycle the block takes at most one word, and it takes it only when the target region has space.

On the output side a scheduler waits until some region is ready to burst. A region is ready when it is completely full, or when the flush input is high and the region holds at least one word. Among the ready regions the scheduler picks one by rotating priority. It first presents a descriptor carrying the channel number and the word count. Once the descriptor is taken, it streams exactly that many words from the region, back to back in arrival order, and marks the final word. The master uses the descriptor to open one burst per destination. It then consumes the data stream with a valid/ready handshake.

Top module: `vbb_burst_buffer`

## Requirements
- R1: While reset is asserted and immediately after it, all regions are empty: `in_ready` is 1 and both `desc_valid` and `out_valid` are 0.
- R2: A word is accepted when `in_valid` and `in_ready` are both high, and it is stored in the region numbered by `in_dest`. `in_ready` is 0 exactly when that region already holds DEPTH words. While `in_ready` is 0 the offered word is not stored.
- R3: A region that holds DEPTH words becomes eligible without any flush, and its descriptor reports a length of DEPTH.
- R4: With `flush` high, any region holding at least one word is eligible. The descriptor length equals the occupancy of that region in the cycle it is selected, and it is never 0 and never above DEPTH.
- R5: A descriptor is held, unchanged, until `desc_ready` is seen. No data word is presented while a descriptor is pending. Data begins in the cycle after the descriptor handshake.
- R6: After a descriptor of length L, exactly L words of that channel are presented, oldest first. `out_last` is 1 on the L-th word only. While `out_ready` is 0 the word and `out_last` hold.
- R7: The scheduler picks among eligible regions in rotating order, searching from the channel after the one served last. After reset the search starts at channel 0.
- R8: Words that arrive for a channel while that channel's burst is in progress are not part of that burst. They stay stored for a later burst.
- R9: Inputs for different channels may interleave in any pattern. The output is grouped by burst, and the order within each channel is preserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Region for `in_dest` has space |
| in_dest | input | $clog2(NUM_CH) | Destination channel of the input word |
| in_data | input | DATA_W | Input word |
| flush | input | 1 | Make every non-empty region eligible |
| desc_valid | output | 1 | Burst descriptor present |
| desc_ready | input | 1 | Descriptor taken |
| desc_chan | output | $clog2(NUM_CH) | Destination channel of the burst |
| desc_len | output | $clog2(DEPTH)+1 | Word count of the burst |
| out_valid | output | 1 | Burst data word present |
| out_ready | input | 1 | Data word taken |
| out_data | output | DATA_W | Burst data word |
| out_last | output | 1 | Final word of the burst |

## Verification
The bench fills a region to the brim while the descriptor is held back. This checks that the full region refuses further words. A design that compared the counter with the wrong bound would overwrite the oldest unread word, or it would stall one word early. It also writes new words to a channel while that channel is draining. A design that sampled the length late, or read beyond it, would carry the newer words into the current burst. Long random runs mix flush pulses, stalls on both output handshakes and arbitrary tag orders. These runs expose a rotating arbiter that restarts at a fixed channel, as well as `out_last` placed one word off.

// File: rtl/vbb_pkg.sv
package vbb_pkg;
  typedef enum logic [1:0] {
    SCH_IDLE = 2'd0,
    SCH_DESC = 2'd1,
    SCH_DATA = 2'd2
  } sched_e;
endpackage

// File: rtl/vbb_part_ctrl.sv
module vbb_part_ctrl #(
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [PTR_W-1:0] wr_ptr_d, rd_ptr_d;
  logic [CNT_W-1:0] count_d;
  logic             upd;

  always_comb begin
    wr_ptr_d = wr_ptr;
    rd_ptr_d = rd_ptr;
    count_d  = count;
    if (wr_en) wr_ptr_d = wr_ptr + PTR_W'(1);
    if (rd_en) rd_ptr_d = rd_ptr + PTR_W'(1);
    case ({wr_en, rd_en})
      2'b10:   count_d = count + CNT_W'(1);
      2'b01:   count_d = count - CNT_W'(1);
      default: count_d = count;
    endcase
    upd = wr_en | rd_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (upd) begin
      wr_ptr <= wr_ptr_d;
      rd_ptr <= rd_ptr_d;
      count  <= count_d;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> count != FULL_CNT); // R2
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> count != '0); // R6
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT); // R2
endmodule

// File: rtl/vbb_rr_pick.sv
module vbb_rr_pick #(
  parameter int NUM_CH = 8,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] elig,
  input  logic [CH_W-1:0]   last,
  output logic              hit,
  output logic [CH_W-1:0]   pick
);
  logic [CH_W-1:0] idx;

  always_comb begin
    hit  = 1'b0;
    pick = '0;
    idx  = '0;
    for (int k = 1; k <= NUM_CH; k++) begin
      idx = last + CH_W'(k);
      if (!hit && elig[idx]) begin
        hit  = 1'b1;
        pick = idx;
      end
    end
  end
endmodule

// File: rtl/vbb_store.sv
module vbb_store #(
  parameter int DATA_W  = 512,
  parameter int ENTRIES = 512,
  localparam int ADDR_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/vbb_burst_buffer.sv
module vbb_burst_buffer
  import vbb_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DEPTH  = 64,
  parameter int DATA_W = 512,
  localparam int CH_W    = $clog2(NUM_CH),
  localparam int PTR_W   = $clog2(DEPTH),
  localparam int CNT_W   = PTR_W + 1,
  localparam int ENTRIES = NUM_CH * DEPTH,
  localparam int ADDR_W  = CH_W + PTR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CH_W-1:0]   in_dest,
  input  logic [DATA_W-1:0] in_data,
  input  logic              flush,
  output logic              desc_valid,
  input  logic              desc_ready,
  output logic [CH_W-1:0]   desc_chan,
  output logic [CNT_W-1:0]  desc_len,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [PTR_W-1:0] wr_ptr [NUM_CH];
  logic [PTR_W-1:0] rd_ptr [NUM_CH];
  logic [CNT_W-1:0] cnt    [NUM_CH];
  logic [NUM_CH-1:0] elig;

  sched_e           state_q, state_d;
  logic [CH_W-1:0]  chan_q, chan_d, last_q, last_d;
  logic [CNT_W-1:0] len_q, len_d, rem_q, rem_d;
  logic             sch_en;

  logic             accept, pop, hit;
  logic [CH_W-1:0]  pick;

  assign in_ready = cnt[in_dest] != FULL_CNT;
  assign accept   = in_valid & in_ready;
  assign pop      = (state_q == SCH_DATA) & out_ready;

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_part
      vbb_part_ctrl #(.DEPTH(DEPTH)) u_part (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (accept && (in_dest == CH_W'(c))),
        .rd_en  (pop && (chan_q == CH_W'(c))),
        .wr_ptr (wr_ptr[c]),
        .rd_ptr (rd_ptr[c]),
        .count  (cnt[c])
      );
      assign elig[c] = (cnt[c] == FULL_CNT) || (flush && (cnt[c] != '0));
    end
  endgenerate

  vbb_rr_pick #(.NUM_CH(NUM_CH)) u_pick (
    .elig (elig),
    .last (last_q),
    .hit  (hit),
    .pick (pick)
  );

  vbb_store #(.DATA_W(DATA_W), .ENTRIES(ENTRIES)) u_store (
    .clk   (clk),
    .we    (accept),
    .waddr ({in_dest, wr_ptr[in_dest]}),
    .wdata (in_data),
    .raddr ({chan_q, rd_ptr[chan_q]}),
    .rdata (out_data)
  );

  always_comb begin
    state_d = state_q;
    chan_d  = chan_q;
    last_d  = last_q;
    len_d   = len_q;
    rem_d   = rem_q;
    case (state_q)
      SCH_IDLE: begin
        if (hit) begin
          state_d = SCH_DESC;
          chan_d  = pick;
          len_d   = cnt[pick];
        end
      end
      SCH_DESC: begin
        if (desc_ready) begin
          state_d = SCH_DATA;
          rem_d   = len_q;
        end
      end
      SCH_DATA: begin
        if (out_ready) begin
          rem_d = rem_q - CNT_W'(1);
          if (rem_q == CNT_W'(1)) begin
            state_d = SCH_IDLE;
            last_d  = chan_q;
          end
        end
      end
      default: state_d = SCH_IDLE;
    endcase
    sch_en = (state_d != state_q) || (rem_d != rem_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SCH_IDLE;
      chan_q  <= '0;
      last_q  <= CH_W'(NUM_CH - 1);
      len_q   <= '0;
      rem_q   <= '0;
    end else if (sch_en) begin
      state_q <= state_d;
      chan_q  <= chan_d;
      last_q  <= last_d;
      len_q   <= len_d;
      rem_q   <= rem_d;
    end
  end

  assign desc_valid = state_q == SCH_DESC;
  assign desc_chan  = chan_q;
  assign desc_len   = len_q;
  assign out_valid  = state_q == SCH_DATA;
  assign out_last   = out_valid && (rem_q == CNT_W'(1));

  AST_DESC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && !desc_ready |=> desc_valid && $stable(desc_chan) && $stable(desc_len)); // R5
  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({desc_valid, out_valid})); // R5
  AST_DATA_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && desc_ready |=> out_valid); // R5
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> (desc_len != '0) && (desc_len <= FULL_CNT)); // R4
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)); // R6
  AST_PICK_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SCH_IDLE) && hit |-> elig[pick]); // R7
endmodule

// File: tb/vbb_burst_buffer_tb_top.sv
`timescale 1ns/1ps
module vbb_burst_buffer_tb_top;
  localparam int NCH = 4;
  localparam int DEP = 8;
  localparam int DW  = 32;
  localparam int CHW = $clog2(NCH);
  localparam int CW  = $clog2(DEP) + 1;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_ready, flush, desc_valid, desc_ready, out_valid, out_ready, out_last;
  logic [CHW-1:0] in_dest, desc_chan;
  logic [DW-1:0]  in_data, out_data;
  logic [CW-1:0]  desc_len;

  always #2.5 clk = ~clk;

  vbb_burst_buffer #(.NUM_CH(NCH), .DEPTH(DEP), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_dest(in_dest), .in_data(in_data),
    .flush(flush),
    .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_chan(desc_chan), .desc_len(desc_len),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [DW-1:0] q [NCH][$];
  int ms = 0, mchan = 0, mlen = 0, mrem = 0, mlast = NCH - 1;
  int n_full = 0, n_flush = 0, n_block = 0, n_overlap = 0;
  logic [DW-1:0] next_data = 32'h1000_0000;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit v, input int d, input bit fl, input bit dr, input bit orr);
    bit exp_ready;
    bit found;
    @(negedge clk);
    in_valid = v; in_dest = CHW'(d); in_data = next_data;
    flush = fl; desc_ready = dr; out_ready = orr;
    #1;
    exp_ready = q[d].size() < DEP;
    check(in_ready === exp_ready, "R2", "in_ready", longint'(in_ready), longint'(exp_ready));
    check(desc_valid === (ms == 1), "R5", "desc_valid", longint'(desc_valid), longint'(ms == 1));
    if (ms == 1) begin
      check(desc_chan == CHW'(mchan), "R7", "desc_chan", longint'(desc_chan), longint'(mchan));
      check(desc_len == CW'(mlen), "R3 R4", "desc_len", longint'(desc_len), longint'(mlen));
    end
    check(out_valid === (ms == 2), "R5 R6", "out_valid", longint'(out_valid), longint'(ms == 2));
    if (ms == 2) begin
      check(out_data == q[mchan][0], "R6 R8 R9", "out_data", longint'(out_data), longint'(q[mchan][0]));
      check(out_last === (mrem == 1), "R6", "out_last", longint'(out_last), longint'(mrem == 1));
    end
    // model update for the coming edge
    if (ms == 0) begin
      found = 0;
      for (int k = 1; k <= NCH; k++) begin
        int idx;
        idx = (mlast + k) % NCH;
        if (!found && (q[idx].size() == DEP || (fl && q[idx].size() > 0))) begin
          found = 1; mchan = idx; mlen = q[idx].size();
        end
      end
      if (found) begin
        ms = 1;
        if (mlen == DEP) n_full++; else n_flush++;
      end
    end else if (ms == 1) begin
      if (dr) begin ms = 2; mrem = mlen; end
    end else begin
      if (orr) begin
        void'(q[mchan].pop_front());
        mrem--;
        if (mrem == 0) begin ms = 0; mlast = mchan; end
      end
    end
    if (v && exp_ready) begin
      if (ms == 2 && d == mchan) n_overlap++;
      q[d].push_back(in_data);
      next_data = next_data + 32'h0000_0101;
    end
    if (v && !exp_ready) n_block++;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 0; in_dest = '0; in_data = '0; flush = 0; desc_ready = 0; out_ready = 0;
    repeat (3) @(negedge clk);
    #1;
    check(in_ready === 1'b1, "R1", "in_ready in reset", longint'(in_ready), 1);
    check(desc_valid === 1'b0, "R1", "desc_valid in reset", longint'(desc_valid), 0);
    check(out_valid === 1'b0, "R1", "out_valid in reset", longint'(out_valid), 0);
    @(negedge clk); rst_n = 1'b1;

    // R3: one region filled to capacity, no flush
    for (int i = 0; i < DEP; i++) step(1, 2, 0, 1, 1);
    for (int i = 0; i < 15; i++) step(0, 0, 0, 1, 1);
    check(n_full == 1, "R3", "full bursts seen", n_full, 1);

    // R2: descriptor held back, region kept full, extra words refused
    for (int i = 0; i < DEP + 3; i++) step(1, 1, 0, 0, 0);
    check(n_block >= 3, "R2", "refused words", n_block, 3);
    // R8: drain with stalls while the same channel keeps receiving
    for (int i = 0; i < 3; i++) step(1, 1, 0, 1, 0);
    for (int i = 0; i < 12; i++) step(1, 1, 0, 1, (i % 3) != 0);
    check(n_overlap > 0, "R8", "words during own burst", n_overlap, 1);

    // R9 R7: arbitrary interleaving with flushes and stalls
    for (int i = 0; i < 4000; i++)
      step(($urandom % 4) != 0, $urandom % NCH, ($urandom % 16) == 0,
           ($urandom % 4) != 0, ($urandom % 4) != 0);

    // R4: drain everything with flush
    for (int i = 0; i < 300; i++) step(0, 0, 1, 1, 1);
    check(n_flush > 0, "R4", "partial bursts seen", n_flush, 1);
    check(desc_valid === 1'b0 && out_valid === 1'b0, "R4", "idle after drain",
          longint'({desc_valid, out_valid}), 0);

    done = 1;
    summary();
    $finish;
  end
endmodule